// File: doc/BRIEF.md
# Eight-Stage Parallel-Load Serialiser with Output Taps

This block is an eight-stage shift register, fully synchronous to one clock. On every rising edge it does exactly one of three things. It can clear itself. It can capture a whole byte from its parallel inputs. Or it can move its contents one stage toward the output end, taking a new bit from the serial input into the first stage. The first stage is stage 0 and the last is stage 7.

The contents of the three highest stages are brought out as taps. The very last stage also drives the serial output. The usual use is parallel-to-serial conversion. A byte is captured with one load edge, and then shift edges present it on the serial output, most significant bit first.

Between edges the inputs have no effect, and every output comes straight from a flip-flop. A valid/ready handshake does not suit this block: it has no flow control, and it moves one bit on every clock edge. Its pins therefore stay plain.

Top module: `piso_tap_shifter`

## Requirements
- R1: When `rst` is high at a rising edge, all eight stages become 0, whatever `load_en` and `ser_in` are. After that edge `tap_out` reads 0 and `ser_out` reads 0.
- R2: When `rst` is low and `load_en` is high at a rising edge, stage k takes `par_in[k]` for every k from 0 to 7. After that edge `tap_out` equals `par_in[7:5]`. Bit i of `tap_out` shows stage 5+i.
- R3: When `rst` and `load_en` are both low at a rising edge, stage 0 takes `ser_in` and each stage k from 1 to 7 takes the value that stage k-1 held before the edge. After that edge `tap_out[2:1]` equals the previous `tap_out[1:0]`.
- R4: On any edge where `load_en` is high, `ser_in` has no effect on the stored byte.
- R5: Suppose the register holds all zeros and `ser_in` is 1 on one shift edge and 0 on the shift edges after it. Then `ser_out` is 0 after each of the next six shift edges, 1 after the seventh, and 0 again after the eighth.
- R6: After a load edge, `ser_out` shows `par_in[7]`. After each further shift edge it shows the next lower loaded bit, down to `par_in[0]` after the seventh shift.
- R7: Outputs change only at rising edges of `clk`. Changing any input between edges leaves `tap_out` and `ser_out` unchanged.
- R8: `ser_out` always equals `tap_out[2]`, the last stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high; highest priority |
| load_en | input | 1 | Parallel capture when high; shift when low |
| ser_in | input | 1 | Serial bit entering stage 0 on shift edges |
| par_in | input | 8 | Parallel byte; bit k goes to stage k on a load edge |
| tap_out | output | 3 | Stages 7..5, as bits 2..0 |
| ser_out | output | 1 | Stage 7, the serial output |

## Verification
The assertions take for granted that `rst`, `load_en`, `ser_in` and `par_in` carry known values at every rising edge. They also assume these inputs settle away from the edge, so that the value sampled at each edge is the value the property refers to in its `$past` term. The bench only changes inputs on falling edges, or at points well away from a rising edge. It holds every control input at a defined level from time zero and asserts reset before any other activity.

// File: rtl/pts_pkg.sv
package pts_pkg;

  // Operation applied to every stage on a rising edge
  typedef enum logic [1:0] {
    OP_CLEAR = 2'd0,
    OP_LOAD  = 2'd1,
    OP_SHIFT = 2'd2
  } pts_op_e;

endpackage

// File: rtl/pts_ctrl.sv
// Decodes the control pins into one operation. Priority: clear, load, shift.
module pts_ctrl
  import pts_pkg::*;
(
  input  logic    rst,
  input  logic    load_en,
  output pts_op_e op
);

  always_comb begin
    if (rst)          op = OP_CLEAR;
    else if (load_en) op = OP_LOAD;
    else              op = OP_SHIFT;
  end

endmodule

// File: rtl/pts_stage.sv
// One storage stage with its own source multiplexer.
module pts_stage
  import pts_pkg::*;
(
  input  logic    clk,
  input  pts_op_e op,
  input  logic    shift_d,
  input  logic    load_d,
  output logic    q
);

  always_ff @(posedge clk) begin
    case (op)
      OP_CLEAR: q <= 1'b0;
      OP_LOAD:  q <= load_d;
      OP_SHIFT: q <= shift_d;
      default:  q <= 1'b0;
    endcase
  end

endmodule

// File: rtl/piso_tap_shifter.sv
module piso_tap_shifter
  import pts_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int TAPS  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_en,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  output logic [TAPS-1:0]  tap_out,
  output logic             ser_out
);

  localparam int TAP_LO = WIDTH - TAPS;

  pts_op_e          op;
  logic [WIDTH-1:0] stage_q;
  logic [WIDTH-1:0] shift_src;

  pts_ctrl u_ctrl (
    .rst     (rst),
    .load_en (load_en),
    .op      (op)
  );

  // Each stage shifts from the one below it; stage 0 shifts from ser_in
  assign shift_src = {stage_q[WIDTH-2:0], ser_in};

  generate
    for (genvar k = 0; k < WIDTH; k++) begin : g_stage
      pts_stage u_stage (
        .clk     (clk),
        .op      (op),
        .shift_d (shift_src[k]),
        .load_d  (par_in[k]),
        .q       (stage_q[k])
      );
    end
  endgenerate

  // Outputs come directly from stage flip-flops
  assign tap_out = stage_q[WIDTH-1:TAP_LO];
  assign ser_out = stage_q[WIDTH-1];

endmodule

// File: rtl/pts_checker.sv
module pts_checker #(
  parameter int WIDTH = 8,
  parameter int TAPS  = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             load_en,
  input logic             ser_in,
  input logic [WIDTH-1:0] par_in,
  input logic [TAPS-1:0]  tap_out,
  input logic             ser_out
);

  localparam int TAP_LO = WIDTH - TAPS;

  // R1: the first cycle after reset shows an all-zero register
  a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (tap_out == '0) && !ser_out);

  // R2 and R4: a load edge exposes the upper parallel bits, whatever ser_in is
  a_r2_load_taps: assert property (@(posedge clk) disable iff (rst)
    load_en |=> tap_out == $past(par_in[WIDTH-1:TAP_LO]));

  // R3: a shift edge moves the visible taps up by one
  a_r3_shift_moves: assert property (@(posedge clk) disable iff (rst)
    !load_en |=> tap_out[TAPS-1:1] == $past(tap_out[TAPS-2:0]));

  // R6: one shift after a load shows the next lower loaded bit
  a_r6_second_bit: assert property (@(posedge clk) disable iff (rst)
    load_en ##1 !load_en |=> ser_out == $past(par_in[WIDTH-2], 2));

  // R8: the serial output is the top tap
  a_r8_ser_is_top: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ser_out == tap_out[TAPS-1]);

endmodule

bind piso_tap_shifter pts_checker #(.WIDTH(WIDTH), .TAPS(TAPS)) u_pts_checker (
  .clk     (clk),
  .rst     (rst),
  .load_en (load_en),
  .ser_in  (ser_in),
  .par_in  (par_in),
  .tap_out (tap_out),
  .ser_out (ser_out)
);

// File: tb/test_piso_tap_shifter.sv
`timescale 1ns/1ps
module test_piso_tap_shifter;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       load_en = 1'b0;
  logic       ser_in = 1'b0;
  logic [7:0] par_in = 8'h00;
  logic [2:0] tap_out;
  logic       ser_out;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  // Bench-side model of the eight stages
  logic [7:0] mdl = 8'h00;

  always #5 clk = ~clk;

  piso_tap_shifter i_piso_tap_shifter (
    .clk     (clk),
    .rst     (rst),
    .load_en (load_en),
    .ser_in  (ser_in),
    .par_in  (par_in),
    .tap_out (tap_out),
    .ser_out (ser_out)
  );

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Drive inputs at a falling edge, take one rising edge, update the model, sample
  task automatic step(input logic r, input logic ld, input logic s, input logic [7:0] p);
    @(negedge clk);
    rst = r; load_en = ld; ser_in = s; par_in = p;
    @(posedge clk);
    if (r)       mdl = 8'h00;
    else if (ld) mdl = p;
    else         mdl = {mdl[6:0], s};
    #2;
  endtask

  task automatic check_model(input string req);
    check(req, {1'b0, tap_out}, {1'b0, mdl[7:5]});
    check("R8", {3'b0, ser_out}, {3'b0, tap_out[2]});
  endtask

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset wins over a load of all ones
    step(1'b1, 1'b1, 1'b1, 8'hFF);
    check("R1 reset over load", {1'b0, tap_out}, 4'h0);
    check("R1 ser_out", {3'b0, ser_out}, 4'h0);

    // Load a pattern, then show reset clears it
    step(1'b0, 1'b1, 1'b0, 8'hE0);
    check_model("R2 load E0");
    step(1'b1, 1'b0, 1'b1, 8'h00);
    check("R1 clears loaded", {1'b0, tap_out}, 4'h0);

    // R7: inputs changed between edges leave outputs alone
    step(1'b0, 1'b1, 1'b0, 8'hA0);
    @(negedge clk);
    load_en = 1'b1; par_in = 8'h5F; ser_in = 1'b1;
    #2;
    check("R7 mid-cycle change", {1'b0, tap_out}, 4'h5);
    par_in = 8'h00; load_en = 1'b0;
    #1;
    check("R7 second change", {3'b0, ser_out}, 4'h1);

    // R5: walking one from ser_in to ser_out
    step(1'b1, 1'b0, 1'b0, 8'h00);
    step(1'b0, 1'b0, 1'b1, 8'h00);
    for (int j = 1; j <= 8; j++) begin
      step(1'b0, 1'b0, 1'b0, 8'h00);
      check($sformatf("R5 walk edge %0d", j), {3'b0, ser_out}, {3'b0, (j == 7)});
    end

    // R2, R3, R4, R6: every byte loaded, then shifted out with varied serial bits
    for (int v = 0; v < 256; v++) begin
      logic [7:0] pv;
      logic [7:0] sbits;
      pv = 8'(v);
      sbits = 8'((v * 37 + 11) & 8'hFF);
      // ser_in opposite to par_in[0] on the load edge: R4
      step(1'b0, 1'b1, ~pv[0], pv);
      check("R2 taps after load", {1'b0, tap_out}, {1'b0, pv[7:5]});
      check("R4 ser_in ignored", {3'b0, ser_out}, {3'b0, pv[7]});
      check_model("R2 model");
      for (int k = 1; k <= 8; k++) begin
        step(1'b0, 1'b0, sbits[k-1], pv);
        if (k <= 7)
          check("R6 serial order", {3'b0, ser_out}, {3'b0, pv[7-k]});
        check_model("R3 shift");
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule